// File: doc/BRIEF.md
# Multi-Granule Translation Table Walker

This block turns one 48-bit virtual address into a physical address by walking a hierarchical translation table held in memory. The caller supplies the virtual address, the address of the first table, a granule code, a region-size field and a stage select. The walker picks its starting level from the granule and the size field. It then reads one 64-bit descriptor per level over a plain request/response memory port until it reaches a leaf entry or finds an invalid one.

On completion it pulses either a done or a fault strobe. With the strobe it presents the physical address, the mask of address bits covered by the page, a write-permission flag and the level at which the walk ended. The three granule sizes differ in three ways: which address bits index each level, which levels may hold a block mapping, and where the contiguous hint widens the page.

A new walk may start only while the walker is idle. Only one descriptor read is ever in flight.

Top module: `table_walker`

## Requirements
- R1: Granule code 0 selects 4 KB, 1 selects 16 KB, 2 selects 64 KB. The first level comes from `req_tsz`. For 4 KB, 16..24 starts at level 0, 25..33 at level 1 and 34..39 at level 2. For 16 KB, 16 starts at level 0, 17..27 at level 1, 28..38 at level 2 and 39 at level 3. For 64 KB, 12..21 starts at level 1, 22..34 at level 2 and 35..39 at level 3. Any other size value, or granule code 3, gives a fault at level 0 with no memory read.
- R2: Each descriptor is read at table base + 8 × index. The index fields are: for 4 KB, VA[47:39], VA[38:30], VA[29:21] and VA[20:12] for levels 0..3; for 16 KB, VA[47], VA[46:36], VA[35:25] and VA[24:14]; for 64 KB, VA[47:42], VA[41:29] and VA[28:16] for levels 1..3.
- R3: At levels 0..2 a descriptor is valid when bit 0 is set. At level 3 it is valid only when bits 0 and 1 are both set. An invalid descriptor ends the walk with a fault that reports that level, with a zero address, a zero mask and a clear write flag.
- R4: A valid descriptor at level 3 is always a page. At level 1 (4 KB only) and at level 2, bit 1 clear marks a block. At level 0, and at level 1 for 16 KB and 64 KB, the descriptor is always followed as a table, whatever bit 1 holds.
- R5: The next table base is descriptor bits [47:12] for 4 KB and 16 KB, and bits [47:16] for 64 KB, with the low bits cleared.
- R6: A leaf gives these page sizes: for 4 KB, 1 GB at level 1, 2 MB at level 2 and 4 KB at level 3; for 16 KB, 32 MB at level 2 and 16 KB at level 3; for 64 KB, 512 MB at level 2 and 64 KB at level 3. The mask has every bit from 47 down to the page boundary set. The physical address is the descriptor bits under the mask ORed with the virtual-address bits below it.
- R7: Descriptor bit 52 set widens the page. It gives 64 KB at 4 KB level 3, 1 GB at 16 KB level 2, 2 MB at 16 KB level 3 and 2 MB at 64 KB level 3. It has no effect elsewhere.
- R8: At stage 2 (`req_stage2`=1) the leaf is writable when bits [7:6] are 2'b11. At stage 1 it is writable when bit 7 is 0.
- R9: `mem_req_valid` is a one-cycle pulse, and no new read is issued before the previous response returns. `req_ready` is high only when idle, and a request raised while busy is ignored.
- R10: `rsp_done` and `rsp_fault` are one-cycle pulses that are never high together. The result outputs change only in a strobe cycle and then hold until the next result.
- R11: After reset `req_ready` is 1, the strobes and `mem_req_valid` are 0, and the result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_ready | output | 1 | Walker idle and able to take a walk |
| req_va | input | 48 | Virtual address to translate |
| req_base | input | 48 | Address of the first-level table |
| req_granule | input | 2 | Granule code: 0=4 KB, 1=16 KB, 2=64 KB |
| req_tsz | input | 6 | Region-size field selecting the start level |
| req_stage2 | input | 1 | 1 selects the stage-2 permission rule |
| mem_req_valid | output | 1 | Descriptor read request pulse |
| mem_req_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 64 | Descriptor contents |
| rsp_done | output | 1 | Walk ended on a leaf |
| rsp_fault | output | 1 | Walk ended on a fault |
| rsp_pa | output | 48 | Physical address |
| rsp_mask | output | 48 | Page mask (bits above the page offset) |
| rsp_writable | output | 1 | Leaf grants write permission |
| rsp_level | output | 2 | Level where the walk ended |

## Verification
The bench targets each range boundary of the size field for every granule, since an off-by-one start level would read the wrong table entry and return a different address. It feeds block-encoded descriptors at levels that may not hold blocks (level 0, and level 1 with 16 KB and 64 KB); a walker that stopped there would end one or two reads early. A 64 KB table pointer with bits [15:12] set exposes a walker that keeps the 4 KB pointer width, because its second read address would be wrong. Contiguous-hint leaves at every level where the hint applies catch a mask that fails to widen. A request raised mid-walk catches a walker that restarts while busy.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int ADDR_W     = 48;
    localparam int DESC_W     = 64;
    localparam int LVL_W      = 2;
    localparam int SHIFT_W    = 6;
    localparam int TSZ_W      = 6;
    localparam int CONTIG_BIT = 52;
    localparam int ENTRY_SH   = 3;   // 8-byte descriptors

    typedef enum logic [1:0] {
        GR_4K  = 2'd0,
        GR_16K = 2'd1,
        GR_64K = 2'd2,
        GR_BAD = 2'd3
    } gran_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ISSUE, S_WAIT, S_DECODE, S_DONE, S_FAULT
    } wstate_e;

    typedef struct packed {
        wstate_e             st;
        logic [LVL_W-1:0]    lvl;
        logic [ADDR_W-1:0]   tbase;
        logic [ADDR_W-1:0]   va;
        gran_e               gran;
        logic                stage2;
        logic [DESC_W-1:0]   desc;
        logic [ADDR_W-1:0]   pa;
        logic [ADDR_W-1:0]   mask;
        logic                wr;
        logic [LVL_W-1:0]    rlvl;
    } walk_ctx_t;

    // Lowest VA bit indexed at a level; also the leaf page boundary there.
    function automatic logic [SHIFT_W-1:0] lvl_lsb(gran_e g, logic [LVL_W-1:0] l);
        int k;
        k = 3 - int'(l);
        case (g)
            GR_16K:  return SHIFT_W'(14 + 11 * k);
            GR_64K:  return SHIFT_W'(16 + 13 * k);
            default: return SHIFT_W'(12 + 9 * k);
        endcase
    endfunction

    function automatic int lvl_width(gran_e g, logic [LVL_W-1:0] l);
        case (g)
            GR_16K:  return (l == 2'd0) ? 1 : 11;
            GR_64K:  return (l == 2'd1) ? 6 : 13;
            default: return 9;
        endcase
    endfunction

    function automatic logic block_ok(gran_e g, logic [LVL_W-1:0] l);
        return (l == 2'd2) || ((l == 2'd1) && (g == GR_4K));
    endfunction

    function automatic logic [SHIFT_W-1:0] page_lsb(gran_e g, logic [LVL_W-1:0] l, logic contig);
        logic [SHIFT_W-1:0] n;
        n = lvl_lsb(g, l);
        if (contig) begin
            case (g)
                GR_4K:   if (l == 2'd3) n = SHIFT_W'(16);
                GR_16K:  if (l == 2'd2) n = SHIFT_W'(30);
                         else if (l == 2'd3) n = SHIFT_W'(21);
                GR_64K:  if (l == 2'd3) n = SHIFT_W'(21);
                default: n = n;
            endcase
        end
        return n;
    endfunction

    function automatic logic [ADDR_W-1:0] low_ones(int n);
        return (ADDR_W'(1) << n) - ADDR_W'(1);
    endfunction

endpackage

// File: rtl/tw_start_sel.sv
module tw_start_sel
    import tw_pkg::*;
(
    input  gran_e              gran,
    input  logic [TSZ_W-1:0]   tsz,
    output logic [LVL_W-1:0]   lvl,
    output logic               bad
);
    always_comb begin
        lvl = '0;
        bad = 1'b0;
        case (gran)
            GR_4K: begin
                if (tsz >= 6'd16 && tsz <= 6'd24)      lvl = 2'd0;
                else if (tsz >= 6'd25 && tsz <= 6'd33) lvl = 2'd1;
                else if (tsz >= 6'd34 && tsz <= 6'd39) lvl = 2'd2;
                else                                    bad = 1'b1;
            end
            GR_16K: begin
                if (tsz == 6'd16)                       lvl = 2'd0;
                else if (tsz >= 6'd17 && tsz <= 6'd27) lvl = 2'd1;
                else if (tsz >= 6'd28 && tsz <= 6'd38) lvl = 2'd2;
                else if (tsz == 6'd39)                  lvl = 2'd3;
                else                                    bad = 1'b1;
            end
            GR_64K: begin
                if (tsz >= 6'd12 && tsz <= 6'd21)      lvl = 2'd1;
                else if (tsz >= 6'd22 && tsz <= 6'd34) lvl = 2'd2;
                else if (tsz >= 6'd35 && tsz <= 6'd39) lvl = 2'd3;
                else                                    bad = 1'b1;
            end
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/tw_desc_decode.sv
module tw_desc_decode
    import tw_pkg::*;
(
    input  gran_e               gran,
    input  logic [LVL_W-1:0]    lvl,
    input  logic [DESC_W-1:0]   desc,
    input  logic [ADDR_W-1:0]   va,
    input  logic                stage2,
    output logic                valid,
    output logic                leaf,
    output logic [ADDR_W-1:0]   next_base,
    output logic [ADDR_W-1:0]   mask,
    output logic [ADDR_W-1:0]   pa,
    output logic                writable
);
    localparam logic [LVL_W-1:0] LAST = LVL_W'(3);

    logic [SHIFT_W-1:0] tbl_sh;
    logic [SHIFT_W-1:0] pg_sh;
    logic               unused_bits;

    assign unused_bits = ^{desc[DESC_W-1:CONTIG_BIT+1], desc[CONTIG_BIT-1:ADDR_W], desc[5:2]};

    always_comb begin
        valid     = (lvl == LAST) ? (desc[0] & desc[1]) : desc[0];
        leaf      = (lvl == LAST) || (block_ok(gran, lvl) && !desc[1]);
        tbl_sh    = (gran == GR_64K) ? SHIFT_W'(16) : SHIFT_W'(12);
        next_base = desc[ADDR_W-1:0] & ~low_ones(int'(tbl_sh));
        pg_sh     = page_lsb(gran, lvl, desc[CONTIG_BIT]);
        mask      = ~low_ones(int'(pg_sh));
        pa        = (desc[ADDR_W-1:0] & mask) | (va & ~mask);
        writable  = stage2 ? (desc[7:6] == 2'b11) : !desc[7];
    end
endmodule

// File: rtl/table_walker.sv
module table_walker
    import tw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_va,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [1:0]           req_granule,
    input  logic [TSZ_W-1:0]     req_tsz,
    input  logic                 req_stage2,
    output logic                 mem_req_valid,
    output logic [ADDR_W-1:0]    mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [DESC_W-1:0]    mem_rsp_data,
    output logic                 rsp_done,
    output logic                 rsp_fault,
    output logic [ADDR_W-1:0]    rsp_pa,
    output logic [ADDR_W-1:0]    rsp_mask,
    output logic                 rsp_writable,
    output logic [LVL_W-1:0]     rsp_level
);
    walk_ctx_t q, d;

    logic [LVL_W-1:0]  start_lvl;
    logic              start_bad;
    logic              dec_valid, dec_leaf, dec_wr;
    logic [ADDR_W-1:0] dec_next, dec_mask, dec_pa;
    logic [ADDR_W-1:0] idx;

    tw_start_sel u_start (
        .gran (gran_e'(req_granule)),
        .tsz  (req_tsz),
        .lvl  (start_lvl),
        .bad  (start_bad)
    );

    tw_desc_decode u_dec (
        .gran      (q.gran),
        .lvl       (q.lvl),
        .desc      (q.desc),
        .va        (q.va),
        .stage2    (q.stage2),
        .valid     (dec_valid),
        .leaf      (dec_leaf),
        .next_base (dec_next),
        .mask      (dec_mask),
        .pa        (dec_pa),
        .writable  (dec_wr)
    );

    always_comb begin
        idx = (q.va >> lvl_lsb(q.gran, q.lvl)) & low_ones(lvl_width(q.gran, q.lvl));
    end

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.va     = req_va;
                    d.tbase  = req_base;
                    d.gran   = gran_e'(req_granule);
                    d.stage2 = req_stage2;
                    d.lvl    = start_lvl;
                    if (start_bad) begin
                        d.st   = S_FAULT;
                        d.rlvl = '0;
                        d.pa   = '0;
                        d.mask = '0;
                        d.wr   = 1'b0;
                    end else begin
                        d.st = S_ISSUE;
                    end
                end
            end
            S_ISSUE: d.st = S_WAIT;
            S_WAIT: begin
                if (mem_rsp_valid) begin
                    d.desc = mem_rsp_data;
                    d.st   = S_DECODE;
                end
            end
            S_DECODE: begin
                if (!dec_valid) begin
                    d.st   = S_FAULT;
                    d.rlvl = q.lvl;
                    d.pa   = '0;
                    d.mask = '0;
                    d.wr   = 1'b0;
                end else if (dec_leaf) begin
                    d.st   = S_DONE;
                    d.rlvl = q.lvl;
                    d.pa   = dec_pa;
                    d.mask = dec_mask;
                    d.wr   = dec_wr;
                end else begin
                    d.st    = S_ISSUE;
                    d.tbase = dec_next;
                    d.lvl   = q.lvl + LVL_W'(1);
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == S_IDLE);
    assign mem_req_valid = (q.st == S_ISSUE);
    assign mem_req_addr  = q.tbase + (idx << ENTRY_SH);
    assign rsp_done      = (q.st == S_DONE);
    assign rsp_fault     = (q.st == S_FAULT);
    assign rsp_pa        = q.pa;
    assign rsp_mask      = q.mask;
    assign rsp_writable  = q.wr;
    assign rsp_level     = q.rlvl;

    // R9
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R9
    busy_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_done && rsp_fault));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_done || rsp_fault) |-> ($stable(rsp_pa) && $stable(rsp_mask) && $stable(rsp_writable)));

    // R3
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_pa == '0 && rsp_mask == '0 && !rsp_writable));

    // R6
    mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_mask[ADDR_W-1] && !rsp_mask[11]));

    // R4
    leaf_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_level != '0));

endmodule

// File: tb/test_table_walker.sv
`timescale 1ns/1ps
module test_table_walker;
    import tw_pkg::*;

    typedef struct packed {
        logic [1:0]  gran;
        logic [5:0]  tsz;
        logic        st2;
        logic [47:0] va;
        logic [63:0] d0, d1, d2, d3;
        logic        fault;
        logic [1:0]  lvl;
        logic [47:0] pa;
        logic [47:0] mask;
        logic        wr;
        logic [2:0]  nrd;
        logic [47:0] a0;
        logic [47:0] a1;
    } vec_t;

    localparam logic [47:0] BASE = 48'h0000_1000_0000;
    localparam int NV = 18;

    localparam vec_t VECS [NV] = '{
        // 0: 4K full walk from level 0 (R1 R2 R5 R6 R8)
        '{2'd0, 6'd16, 1'b0, 48'h0080_4020_1ABC, 64'h2000_0003, 64'h3000_0003, 64'h4000_0003, 64'h5555_5003,
          1'b0, 2'd3, 48'h0000_5555_5ABC, 48'hFFFF_FFFF_F000, 1'b1, 3'd4, 48'h0000_1000_0008, 48'h0000_2000_0008},
        // 1: 4K 1 GB block at level 1, stage1 bit7 set (R4 R6 R8)
        '{2'd0, 6'd25, 1'b0, 48'h0001_4020_1ABC, 64'h0000_00C0_0000_0081, 64'h0, 64'h0, 64'h0,
          1'b0, 2'd1, 48'h00C0_0020_1ABC, 48'hFFFF_C000_0000, 1'b0, 3'd1, 48'h0000_1000_0028, 48'h0},
        // 2: 4K 2 MB block, stage2 writable (R6 R8)
        '{2'd0, 6'd34, 1'b1, 48'h0000_0020_1ABC, 64'h0000_0001_2340_00C1, 64'h0, 64'h0, 64'h0,
          1'b0, 2'd2, 48'h0001_2340_1ABC, 48'hFFFF_FFE0_0000, 1'b1, 3'd1, 48'h0000_1000_0008, 48'h0},
        // 3: 4K contiguous page -> 64 KB (R7)
        '{2'd0, 6'd34, 1'b0, 48'h0000_0020_1ABC, 64'h2000_0003, 64'h0010_0000_7777_0003, 64'h0, 64'h0,
          1'b0, 2'd3, 48'h0000_7777_1ABC, 48'hFFFF_FFFF_0000, 1'b1, 3'd2, 48'h0000_1000_0008, 48'h0000_2000_0008},
        // 4: 16K from level 0, block code at L1 followed as table, contiguous L2 -> 1 GB (R4 R7)
        '{2'd1, 6'd16, 1'b0, 48'h8010_0200_5ABC, 64'h2000_0003, 64'h3000_0001, 64'h0010_0080_0000_0001, 64'h0,
          1'b0, 2'd2, 48'h0080_0200_5ABC, 48'hFFFF_C000_0000, 1'b1, 3'd3, 48'h0000_1000_0008, 48'h0000_2000_0008},
        // 5: 16K start level 3, 16 KB page stage2 (R1 R6)
        '{2'd1, 6'd39, 1'b1, 48'h0000_0000_5ABC, 64'h0000_0000_1234_C0C3, 64'h0, 64'h0, 64'h0,
          1'b0, 2'd3, 48'h0000_1234_DABC, 48'hFFFF_FFFF_C000, 1'b1, 3'd1, 48'h0000_1000_0008, 48'h0},
        // 6: 16K contiguous page at L3 -> 2 MB (R7)
        '{2'd1, 6'd28, 1'b0, 48'h0000_0200_5ABC, 64'h2000_0003, 64'h0010_0000_0060_0083, 64'h0, 64'h0,
          1'b0, 2'd3, 48'h0000_0060_5ABC, 48'hFFFF_FFE0_0000, 1'b0, 3'd2, 48'h0000_1000_0008, 48'h0000_2000_0008},
        // 7: 64K from L1, pointer width [47:16], contiguous -> 2 MB, stage2 not writable (R5 R7 R8)
        '{2'd2, 6'd12, 1'b1, 48'h0400_2001_ABCD, 64'h2001_F001, 64'h3000_0003, 64'h0010_0000_4560_0043, 64'h0,
          1'b0, 2'd3, 48'h0000_4561_ABCD, 48'hFFFF_FFE0_0000, 1'b0, 3'd3, 48'h0000_1000_0008, 48'h0000_2001_0008},
        // 8: 64K 512 MB block, index 3 (R2 R6)
        '{2'd2, 6'd22, 1'b0, 48'h0000_6001_ABCD, 64'h0000_0000_C000_0001, 64'h0, 64'h0, 64'h0,
          1'b0, 2'd2, 48'h0000_C001_ABCD, 48'hFFFF_E000_0000, 1'b1, 3'd1, 48'h0000_1000_0018, 48'h0},
        // 9: 64K start level 3, 64 KB page (R1 R6)
        '{2'd2, 6'd35, 1'b0, 48'h0000_0001_ABCD, 64'h0000_0000_789A_0003, 64'h0, 64'h0, 64'h0,
          1'b0, 2'd3, 48'h0000_789A_ABCD, 48'hFFFF_FFFF_0000, 1'b1, 3'd1, 48'h0000_1000_0008, 48'h0},
        // 10: invalid at level 2 (R3)
        '{2'd0, 6'd25, 1'b0, 48'h0000_4020_1ABC, 64'h2000_0003, 64'h0, 64'h0, 64'h0,
          1'b1, 2'd2, 48'h0, 48'h0, 1'b0, 3'd2, 48'h0000_1000_0008, 48'h0000_2000_0008},
        // 11: level 3 with bit1 clear is invalid (R3)
        '{2'd0, 6'd34, 1'b0, 48'h0000_0020_1ABC, 64'h2000_0003, 64'h5555_5001, 64'h0, 64'h0,
          1'b1, 2'd3, 48'h0, 48'h0, 1'b0, 3'd2, 48'h0000_1000_0008, 48'h0000_2000_0008},
        // 12..15: unsupported size / granule (R1)
        '{2'd0, 6'd40, 1'b0, 48'h0, 64'h0, 64'h0, 64'h0, 64'h0, 1'b1, 2'd0, 48'h0, 48'h0, 1'b0, 3'd0, 48'h0, 48'h0},
        '{2'd1, 6'd15, 1'b0, 48'h0, 64'h0, 64'h0, 64'h0, 64'h0, 1'b1, 2'd0, 48'h0, 48'h0, 1'b0, 3'd0, 48'h0, 48'h0},
        '{2'd2, 6'd11, 1'b0, 48'h0, 64'h0, 64'h0, 64'h0, 64'h0, 1'b1, 2'd0, 48'h0, 48'h0, 1'b0, 3'd0, 48'h0, 48'h0},
        '{2'd3, 6'd20, 1'b0, 48'h0, 64'h0, 64'h0, 64'h0, 64'h0, 1'b1, 2'd0, 48'h0, 48'h0, 1'b0, 3'd0, 48'h0, 48'h0},
        // 16: 4K tsz 24 boundary, block code at L0 followed as table (R1 R4)
        '{2'd0, 6'd24, 1'b0, 48'h0080_4020_1ABC, 64'h2000_0001, 64'h3000_0003, 64'h4000_0003, 64'h5555_5003,
          1'b0, 2'd3, 48'h0000_5555_5ABC, 48'hFFFF_FFFF_F000, 1'b1, 3'd4, 48'h0000_1000_0008, 48'h0000_2000_0008},
        // 17: invalid at level 0 (R3)
        '{2'd0, 6'd16, 1'b0, 48'h0080_4020_1ABC, 64'h0, 64'h0, 64'h0, 64'h0,
          1'b1, 2'd0, 48'h0, 48'h0, 1'b0, 3'd1, 48'h0000_1000_0008, 48'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_va = '0;
    logic [47:0] req_base = '0;
    logic [1:0]  req_granule = '0;
    logic [5:0]  req_tsz = '0;
    logic        req_stage2 = 1'b0;
    logic        mem_req_valid;
    logic [47:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_done, rsp_fault, rsp_writable;
    logic [47:0] rsp_pa, rsp_mask;
    logic [1:0]  rsp_level;

    logic [63:0] cur_desc [4];
    logic [47:0] rd_log [256];
    logic [7:0]  rd_total = '0;
    logic [7:0]  rd_start = '0;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    table_walker i_table_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_base(req_base), .req_granule(req_granule),
        .req_tsz(req_tsz), .req_stage2(req_stage2),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .rsp_mask(rsp_mask), .rsp_writable(rsp_writable), .rsp_level(rsp_level)
    );

    // Memory model: one-cycle response, descriptors served in read order.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid) begin
            rd_log[rd_total] <= mem_req_addr;
            mem_rsp_data     <= cur_desc[rd_total[1:0] - rd_start[1:0]];
            mem_rsp_valid    <= 1'b1;
            rd_total         <= rd_total + 8'd1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start_walk(input vec_t v);
        @(negedge clk);
        cur_desc[0] = v.d0; cur_desc[1] = v.d1; cur_desc[2] = v.d2; cur_desc[3] = v.d3;
        rd_start    = rd_total;
        req_va      = v.va;
        req_base    = BASE;
        req_granule = v.gran;
        req_tsz     = v.tsz;
        req_stage2  = v.st2;
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid   = 1'b0;
    endtask

    task automatic wait_end(output bit got);
        got = 0;
        for (int c = 0; c < 100; c++) begin
            if (rsp_done || rsp_fault) begin
                got = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_vec(input int n, input vec_t v);
        bit got;
        logic [47:0] pa_snap;
        wait_end(got);
        chk($sformatf("R10 v%0d response seen", n), 64'(got), 64'd1);
        chk($sformatf("R3 v%0d fault strobe", n), 64'(rsp_fault), 64'(v.fault));
        chk($sformatf("R10 v%0d done strobe", n), 64'(rsp_done), 64'(!v.fault));
        chk($sformatf("R1 v%0d level", n), 64'(rsp_level), 64'(v.lvl));
        chk($sformatf("R6 v%0d pa", n), 64'(rsp_pa), 64'(v.pa));
        chk($sformatf("R7 v%0d mask", n), 64'(rsp_mask), 64'(v.mask));
        chk($sformatf("R8 v%0d writable", n), 64'(rsp_writable), 64'(v.wr));
        chk($sformatf("R9 v%0d read count", n), 64'(rd_total - rd_start), 64'(v.nrd));
        if (v.nrd >= 3'd1)
            chk($sformatf("R2 v%0d first read addr", n), 64'(rd_log[rd_start]), 64'(v.a0));
        if (v.nrd >= 3'd2)
            chk($sformatf("R5 v%0d second read addr", n), 64'(rd_log[rd_start + 8'd1]), 64'(v.a1));
        pa_snap = rsp_pa;
        @(negedge clk);
        chk($sformatf("R10 v%0d strobe one cycle", n), 64'(rsp_done | rsp_fault), 64'd0);
        @(negedge clk);
        chk($sformatf("R10 v%0d result held", n), 64'(rsp_pa), 64'(pa_snap));
        chk($sformatf("R9 v%0d ready after walk", n), 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 ready in reset", 64'(req_ready), 64'd1);
        chk("R11 no read in reset", 64'(mem_req_valid), 64'd0);
        chk("R11 no strobe in reset", 64'(rsp_done | rsp_fault), 64'd0);
        chk("R11 pa zero in reset", 64'(rsp_pa), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 ready after reset", 64'(req_ready), 64'd1);
        chk("R11 mask zero after reset", 64'(rsp_mask), 64'd0);

        for (int i = 0; i < NV; i++) begin
            start_walk(VECS[i]);
            check_vec(i, VECS[i]);
        end

        // R9: request raised mid-walk is ignored
        start_walk(VECS[0]);
        @(negedge clk);
        chk("R9 not ready while busy", 64'(req_ready), 64'd0);
        req_va      = VECS[8].va;
        req_granule = VECS[8].gran;
        req_tsz     = VECS[8].tsz;
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid   = 1'b0;
        check_vec(100, VECS[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule